// File: doc/BRIEF.md
# Next-Fetch-Address Predictor

This block sits at the front of an instruction fetch stage. Each cycle it takes the current fetch address and returns the address to fetch next, along with a flag that says whether that address is a predicted redirection away from the sequential path. It combines four sources: a small direct-mapped target buffer, a 2-bit saturating direction counter per buffer entry, a per-entry branch kind, and an eight-deep return-address stack.

The backend reports each resolved control-flow instruction on an update port. A taken resolution that misses the buffer allocates an entry. A resolution that hits trains the entry's counter, kind and target. When the backend detects a misprediction, it raises the redirect input, and the resolved address becomes the next fetch address before every predicted source. Decode, cache access and the flush itself belong to neighbouring blocks.

Top module: `nfp_predictor`

## Requirements
- R1: When the fetch address misses the buffer, next_pc equals fetch_pc + 4 and pred_taken is 0.
- R2: The buffer is direct-mapped with 16 entries. The index is PC bits [5:2] and the tag is every other PC bit. Two addresses with the same index but different tags never hit each other, and a taken allocation from one replaces the other.
- R3: A taken resolution that misses allocates an entry with counter 2'b10. A not-taken resolution that misses allocates nothing.
- R4: A resolution that hits moves the 2-bit counter one step toward its outcome, saturating at 2'b00 and 2'b11. A conditional entry (kind 2'b00) predicts taken to its stored target only when the counter is 2'b10 or 2'b11. A strongly held direction therefore flips only after two opposite outcomes in a row.
- R5: A taken resolution that hits replaces the stored target. A not-taken one leaves the target unchanged.
- R6: A hit on a call entry (kind 2'b01) predicts taken to the stored target and pushes fetch_pc + 4 onto the return stack.
- R7: A hit on a return entry (kind 2'b10) pops the stack and predicts taken to the popped address. The stack holds 8 addresses, and a push onto a full stack overwrites the oldest. A return that hits while the stack is empty predicts fetch_pc + 4, not taken.
- R8: A hit on a jump entry (kind 2'b11) predicts taken to its stored target whatever its counter holds.
- R9: While redir_valid is 1, next_pc equals redir_pc and pred_taken is 0, and the return stack is neither pushed nor popped that cycle.
- R10: An update and a lookup of the same entry in the same cycle give a prediction from the contents the entry held before the update.
- R11: Reset invalidates every buffer entry and empties the return stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| upd_valid | input | 1 | A resolved control-flow instruction is reported |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target address |
| upd_kind | input | 2 | Kind: 00 conditional, 01 call, 10 return, 11 jump |
| redir_valid | input | 1 | Backend misprediction redirect |
| redir_pc | input | 32 | Resolved address to fetch after a redirect |
| next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Next fetch address is a predicted redirection |

## Verification
The assertions check several properties on every cycle: a redirect overrides every other source, a not-taken prediction always falls back to the sequential address, the stack occupancy never exceeds its depth or moves by more than one per cycle, and a redirect leaves that occupancy unchanged. Counter training, allocation policy, target refresh, aliasing within one index, same-cycle update ordering and the oldest-overwrite order of the stack depend on history. Only the bench's sequences can show them, by comparing predictions against hand-computed expectations.

// File: rtl/nfp_pkg.sv
package nfp_pkg;
    localparam int PC_W       = 32;
    localparam int IDX_W      = 4;
    localparam int INST_BYTES = 4;
    localparam int RAS_DEPTH  = 8;   // power of two: the pointer wraps naturally

    localparam int OFS_W      = $clog2(INST_BYTES);
    localparam int BTB_DEPTH  = 1 << IDX_W;
    localparam int TAG_W      = PC_W - IDX_W;
    localparam int RAS_PTR_W  = $clog2(RAS_DEPTH);
    localparam int RAS_CNT_W  = RAS_PTR_W + 1;

    typedef enum logic [1:0] {
        BK_COND = 2'd0,
        BK_CALL = 2'd1,
        BK_RET  = 2'd2,
        BK_JUMP = 2'd3
    } br_kind_e;

    typedef logic [1:0] ctr_t;
    localparam ctr_t CTR_WEAK_TAKEN = 2'b10;

    typedef struct packed {
        logic            valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
        br_kind_e         kind;
        ctr_t             ctr;
    } btb_entry_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
        return pc[OFS_W +: IDX_W];
    endfunction

    // Tag keeps every PC bit that is not part of the index.
    function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
        return {pc[PC_W-1:OFS_W+IDX_W], pc[OFS_W-1:0]};
    endfunction

    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        if (taken) return (c == 2'b11) ? c : c + 2'b01;
        else       return (c == 2'b00) ? c : c - 2'b01;
    endfunction
endpackage

// File: rtl/nfp_btb.sv
module nfp_btb
    import nfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_hit,
    output btb_entry_t        lk_entry,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken,
    input  logic [PC_W-1:0]   up_target,
    input  br_kind_e          up_kind
);
    btb_entry_t mem [BTB_DEPTH];

    logic [IDX_W-1:0] up_idx;
    logic [TAG_W-1:0] up_tag;
    btb_entry_t       up_old;
    btb_entry_t       wr_entry;
    logic             wr_en;

    // Lookup reads the stored array, so a write this cycle is not visible yet.
    always_comb begin
        lk_entry = mem[idx_of(lk_pc)];
        lk_hit   = lk_entry.valid && (lk_entry.tag == tag_of(lk_pc));
    end

    always_comb begin
        up_idx   = idx_of(up_pc);
        up_tag   = tag_of(up_pc);
        up_old   = mem[up_idx];
        wr_entry = up_old;
        wr_en    = 1'b0;
        if (up_valid) begin
            if (up_old.valid && up_old.tag == up_tag) begin
                wr_en        = 1'b1;
                wr_entry.ctr = ctr_step(up_old.ctr, up_taken);
                wr_entry.kind = up_kind;
                if (up_taken) wr_entry.target = up_target;
            end else if (up_taken) begin
                wr_en    = 1'b1;
                wr_entry = '{valid: 1'b1, tag: up_tag, target: up_target,
                             kind: up_kind, ctr: CTR_WEAK_TAKEN};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BTB_DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[up_idx] <= wr_entry;
        end
    end
endmodule

// File: rtl/nfp_ras.sv
module nfp_ras
    import nfp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  logic [PC_W-1:0]      push_addr,
    input  logic                 pop,
    output logic [PC_W-1:0]      top_addr,
    output logic [RAS_CNT_W-1:0] count
);
    logic [PC_W-1:0]      stk [RAS_DEPTH];
    logic [RAS_PTR_W-1:0] wr_ptr;

    assign top_addr = stk[wr_ptr - 1'b1];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (push) begin
            stk[wr_ptr] <= push_addr;
            wr_ptr      <= wr_ptr + 1'b1;
            if (count != RAS_CNT_W'(RAS_DEPTH)) count <= count + 1'b1;
        end else if (pop && count != '0) begin
            wr_ptr <= wr_ptr - 1'b1;
            count  <= count - 1'b1;
        end
    end
endmodule

// File: rtl/nfp_select.sv
module nfp_select
    import nfp_pkg::*;
(
    input  logic [PC_W-1:0]      fetch_pc,
    input  logic                 hit,
    input  br_kind_e             kind,
    input  logic                 dir_taken,
    input  logic [PC_W-1:0]      target,
    input  logic [RAS_CNT_W-1:0] ras_count,
    input  logic [PC_W-1:0]      ras_top,
    input  logic                 redir_valid,
    input  logic [PC_W-1:0]      redir_pc,
    output logic [PC_W-1:0]      next_pc,
    output logic                 pred_taken,
    output logic                 push,
    output logic [PC_W-1:0]      push_addr,
    output logic                 pop
);
    logic [PC_W-1:0] seq_pc;

    always_comb begin
        seq_pc     = fetch_pc + PC_W'(INST_BYTES);
        push_addr  = seq_pc;
        next_pc    = seq_pc;
        pred_taken = 1'b0;
        push       = 1'b0;
        pop        = 1'b0;
        if (redir_valid) begin
            next_pc = redir_pc;
        end else if (hit) begin
            unique case (kind)
                BK_COND: if (dir_taken) begin
                    next_pc    = target;
                    pred_taken = 1'b1;
                end
                BK_CALL: begin
                    next_pc    = target;
                    pred_taken = 1'b1;
                    push       = 1'b1;
                end
                BK_RET: if (ras_count != '0) begin
                    next_pc    = ras_top;
                    pred_taken = 1'b1;
                    pop        = 1'b1;
                end
                BK_JUMP: begin
                    next_pc    = target;
                    pred_taken = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nfp_predictor.sv
module nfp_predictor
    import nfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    input  logic [PC_W-1:0]  upd_target,
    input  logic [1:0]       upd_kind,
    input  logic             redir_valid,
    input  logic [PC_W-1:0]  redir_pc,
    output logic [PC_W-1:0]  next_pc,
    output logic             pred_taken
);
    logic                 lk_hit;
    btb_entry_t           lk_entry;
    logic                 ras_push;
    logic                 ras_pop;
    logic [PC_W-1:0]      ras_push_addr;
    logic [PC_W-1:0]      ras_top;
    logic [RAS_CNT_W-1:0] ras_cnt;

    nfp_btb u_btb (
        .clk       (clk),
        .rst       (rst),
        .lk_pc     (fetch_pc),
        .lk_hit    (lk_hit),
        .lk_entry  (lk_entry),
        .up_valid  (upd_valid),
        .up_pc     (upd_pc),
        .up_taken  (upd_taken),
        .up_target (upd_target),
        .up_kind   (br_kind_e'(upd_kind))
    );

    nfp_ras u_ras (
        .clk       (clk),
        .rst       (rst),
        .push      (ras_push),
        .push_addr (ras_push_addr),
        .pop       (ras_pop),
        .top_addr  (ras_top),
        .count     (ras_cnt)
    );

    nfp_select u_sel (
        .fetch_pc    (fetch_pc),
        .hit         (lk_hit),
        .kind        (lk_entry.kind),
        .dir_taken   (lk_entry.ctr[1]),
        .target      (lk_entry.target),
        .ras_count   (ras_cnt),
        .ras_top     (ras_top),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .next_pc     (next_pc),
        .pred_taken  (pred_taken),
        .push        (ras_push),
        .push_addr   (ras_push_addr),
        .pop         (ras_pop)
    );
endmodule

// File: rtl/nfp_predictor_chk.sv
module nfp_predictor_chk
    import nfp_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 redir_valid,
    input logic [PC_W-1:0]      redir_pc,
    input logic [PC_W-1:0]      fetch_pc,
    input logic [PC_W-1:0]      next_pc,
    input logic                 pred_taken,
    input logic [RAS_CNT_W-1:0] ras_cnt
);
    // R9
    redirect_prio_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (next_pc == redir_pc && !pred_taken));

    // R1
    seq_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (!redir_valid && !pred_taken) |-> next_pc == fetch_pc + PC_W'(INST_BYTES));

    // R7
    ras_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ras_cnt <= RAS_CNT_W'(RAS_DEPTH));

    // R7
    ras_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_cnt != $past(ras_cnt)) |->
            (ras_cnt == $past(ras_cnt) + 1'b1 || ras_cnt == $past(ras_cnt) - 1'b1));

    // R9
    redirect_ras_hold_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> ras_cnt == $past(ras_cnt));

    // R11
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ras_cnt == '0);
endmodule

bind nfp_predictor nfp_predictor_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .fetch_pc    (fetch_pc),
    .next_pc     (next_pc),
    .pred_taken  (pred_taken),
    .ras_cnt     (ras_cnt)
);

// File: tb/nfp_predictor_test.sv
module nfp_predictor_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] K_COND = 2'd0;
    localparam logic [1:0] K_CALL = 2'd1;
    localparam logic [1:0] K_RET  = 2'd2;
    localparam logic [1:0] K_JUMP = 2'd3;

    localparam logic [31:0] IDLE = 32'h0000_0F00;  // never allocated
    localparam logic [31:0] PA   = 32'h0000_0100;  // index 0
    localparam logic [31:0] PB   = 32'h0000_0140;  // index 0, other tag
    localparam logic [31:0] PC_C = 32'h0000_0204;  // call, index 1
    localparam logic [31:0] PC_R = 32'h0000_0308;  // return, index 2
    localparam logic [31:0] PC_J = 32'h0000_040C;  // jump, index 3

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = IDLE;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic [1:0]  upd_kind = '0;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_pc = '0;
    logic [31:0] next_pc;
    logic        pred_taken;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nfp_predictor uut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_kind(upd_kind),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .next_pc(next_pc), .pred_taken(pred_taken)
    );

    typedef struct packed {
        logic        uv;
        logic [31:0] upc;
        logic        ut;
        logic [31:0] utgt;
        logic [1:0]  uk;
        logic [31:0] fpc;
        logic [31:0] enext;
        logic        et;
    } vec_t;

    // Conditional branch training on one index (R1 R2 R3 R4 R5 R10).
    localparam vec_t VECS [16] = '{
        '{1'b0, 32'h0,  1'b0, 32'h0,   K_COND, PA, 32'h104, 1'b0}, // R1 cold miss
        '{1'b1, PA,     1'b0, 32'h0,   K_COND, PA, 32'h104, 1'b0}, // not-taken miss
        '{1'b0, 32'h0,  1'b0, 32'h0,   K_COND, PA, 32'h104, 1'b0}, // R3 nothing allocated
        '{1'b1, PA,     1'b1, 32'h200, K_COND, PA, 32'h104, 1'b0}, // R10 old contents
        '{1'b1, PA,     1'b1, 32'h200, K_COND, PA, 32'h200, 1'b1}, // R3 weak taken, ->11
        '{1'b1, PA,     1'b0, 32'h0,   K_COND, PA, 32'h200, 1'b1}, // 11, ->10
        '{1'b1, PA,     1'b0, 32'h0,   K_COND, PA, 32'h200, 1'b1}, // R4 10 still taken, ->01
        '{1'b1, PA,     1'b0, 32'h0,   K_COND, PA, 32'h104, 1'b0}, // R4 01, ->00
        '{1'b1, PA,     1'b0, 32'h0,   K_COND, PA, 32'h104, 1'b0}, // R4 00 saturates
        '{1'b1, PA,     1'b1, 32'h300, K_COND, PA, 32'h104, 1'b0}, // 00, ->01 tgt 300
        '{1'b1, PA,     1'b1, 32'h300, K_COND, PA, 32'h104, 1'b0}, // 01, ->10
        '{1'b0, 32'h0,  1'b0, 32'h0,   K_COND, PA, 32'h300, 1'b1}, // R5 new target
        '{1'b0, 32'h0,  1'b0, 32'h0,   K_COND, PB, 32'h144, 1'b0}, // R2 alias misses
        '{1'b1, PB,     1'b1, 32'h400, K_COND, PA, 32'h300, 1'b1}, // alias allocates
        '{1'b0, 32'h0,  1'b0, 32'h0,   K_COND, PA, 32'h104, 1'b0}, // R2 replaced
        '{1'b0, 32'h0,  1'b0, 32'h0,   K_COND, PB, 32'h400, 1'b1}  // R2 new owner
    };

    task automatic drive(input logic [31:0] fpc, input logic uv, input logic [31:0] upc,
                         input logic ut, input logic [31:0] utgt, input logic [1:0] uk,
                         input logic rv, input logic [31:0] rpc);
        @(negedge clk);
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        upd_target = utgt; upd_kind = uk; redir_valid = rv; redir_pc = rpc;
        #1;
    endtask

    task automatic fetch(input logic [31:0] fpc);
        drive(fpc, 1'b0, '0, 1'b0, '0, K_COND, 1'b0, '0);
    endtask

    task automatic learn(input logic [31:0] pc, input logic t, input logic [31:0] tgt,
                         input logic [1:0] k);
        drive(IDLE, 1'b1, pc, t, tgt, k, 1'b0, '0);
    endtask

    task automatic expect_pred(input string req, input logic [31:0] en, input logic et);
        checks++;
        if (next_pc !== en || pred_taken !== et) begin
            failures++;
            $display("FAIL %s: next_pc=%h taken=%b expected next_pc=%h taken=%b",
                     req, next_pc, pred_taken, en, et);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < 16; v++) begin
            drive(VECS[v].fpc, VECS[v].uv, VECS[v].upc, VECS[v].ut,
                  VECS[v].utgt, VECS[v].uk, 1'b0, '0);
            expect_pred($sformatf("vector %0d (R1 R2 R3 R4 R5 R10)", v),
                        VECS[v].enext, VECS[v].et);
        end

        // R8: jump entry driven to counter 00 still predicts taken
        learn(PC_J, 1'b1, 32'h900, K_JUMP);
        learn(PC_J, 1'b0, 32'h0, K_JUMP);
        learn(PC_J, 1'b0, 32'h0, K_JUMP);
        fetch(PC_J);
        expect_pred("R8 jump ignores counter", 32'h900, 1'b1);

        learn(PC_C, 1'b1, 32'h1000, K_CALL);
        learn(PC_R, 1'b1, 32'h0, K_RET);

        // R7: return with empty stack
        fetch(PC_R);
        expect_pred("R7 empty stack return", 32'h30C, 1'b0);

        // R6 call pushes, R7 return pops
        fetch(PC_C);
        expect_pred("R6 call predicted taken", 32'h1000, 1'b1);
        fetch(PC_R);
        expect_pred("R6 pushed address returned", 32'h208, 1'b1);
        fetch(PC_R);
        expect_pred("R7 stack empty after pop", 32'h30C, 1'b0);

        // R7: nine pushes, oldest overwritten, eight pops in LIFO order
        for (int k = 0; k < 9; k++) learn(32'h2010 + 32'(4*k), 1'b1, 32'h5000, K_CALL);
        for (int k = 0; k < 9; k++) begin
            fetch(32'h2010 + 32'(4*k));
            expect_pred("R6 call site", 32'h5000, 1'b1);
        end
        for (int k = 8; k >= 1; k--) begin
            fetch(PC_R);
            expect_pred("R7 full stack pop order", 32'h2014 + 32'(4*k), 1'b1);
        end
        fetch(PC_R);
        expect_pred("R7 oldest was overwritten", 32'h30C, 1'b0);

        // R9: redirect wins and leaves the stack alone
        fetch(PC_C);
        drive(PC_R, 1'b0, '0, 1'b0, '0, K_COND, 1'b1, 32'h7777_0000);
        expect_pred("R9 redirect over return", 32'h7777_0000, 1'b0);
        fetch(PC_R);
        expect_pred("R9 no pop during redirect", 32'h208, 1'b1);
        drive(PC_C, 1'b0, '0, 1'b0, '0, K_COND, 1'b1, 32'h0000_8000);
        expect_pred("R9 redirect over call", 32'h0000_8000, 1'b0);
        fetch(PC_R);
        expect_pred("R9 no push during redirect", 32'h30C, 1'b0);

        // R11: reset clears buffer and stack
        fetch(PC_C);
        @(negedge clk);
        fetch_pc = IDLE;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        fetch(PC_R);
        expect_pred("R11 return after reset", 32'h30C, 1'b0);
        fetch(PC_C);
        expect_pred("R11 call entry cleared", 32'h208, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule